// File: doc/BRIEF.md
# Double-Buffered Eight-Channel DAC Register Front End

This block is the digital side of a multi-channel digital-to-analog converter. A host reaches it over a 16-bit parallel bus with an active-low chip select, a read/write line and a 5-bit word address. All bus inputs are sampled on the rising clock edge. The block decodes each access into a small set of control words and three banks of per-channel words: input, zero-trim and gain-trim. Read data and a bus drive enable are registered. A pad ring uses the enable to drive the shared data bus, and the bus floats whenever the enable is low.

Each channel has three stages. The input word is what the host writes. The DAC data word follows the input word one cycle later, standing in for the correction stage, which lies outside this block. The output latch feeds the converter. The update mode is fixed during reset by the level of the active-low load strobe. In synchronous mode the latches copy their data words only on edges where the strobe is low, so every channel changes on the same cycle. In asynchronous mode the latches copy the data words on every cycle and the strobe is ignored.

The block also holds two group offset codes, a monitor-select word with at most one select bit set, and an open-drain general-purpose pin control.

Top module: `dacif_regfile`

## Requirements
- R1: While `rst` is high, the following load 8000h if `reset_sel` is 1 and 0000h if it is 0: every input word, every DAC data word, every output latch, and both offsets. Zero-trim words reset to 0000h, gain-trim words to FFFFh, the GPIO word to 8000h, and config and monitor to 0000h.
- R2: An access happens on an edge with `cs_n`=0. `rw`=0 writes and `rw`=1 reads. The address map is:
  - 0: config
  - 1: monitor
  - 2: GPIO
  - 3: offset A
  - 4: offset B
  - 5 to 7: reserved, read as 0000h, writes ignored
  - 8+n: input word of channel n
  - 16+n: zero-trim word of channel n
  - 24+n: gain-trim word of channel n
- R3: A read sampled at edge k shows the addressed word on `rd_data`, with `rd_en`=1, for the one cycle after edge k. At every other time `rd_en` is 0 and `rd_data` is 0000h.
- R4: The DAC data word of a channel takes its input word one edge after the input write.
- R5: In synchronous mode (`load_n`=1 during reset), a latch updates only on edges where `load_n`=0. All channels load at the same edge, and `dac_code` holds while `load_n`=1.
- R6: In asynchronous mode (`load_n`=0 during reset), an input write at edge k reaches `dac_code` after edge k+2, whatever the level of `load_n`.
- R7: A monitor write is ignored if more than one of data bits 15..4 is set. Bits 3..0 are stored as zero. `mon_sel` equals bits 15..4, and `mon_en` is 1 exactly when any of those bits is set.
- R8: GPIO keeps only bit 15 and reads back as {bit15, 15'b0}. `gpio_drive_low` is the inverse of that bit: writing 0 pulls the pin low and writing 1 releases it.
- R9: Config and offset writes take effect on the outputs and on readback right after the write edge, with no strobe needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_sel | input | 1 | Reset code choice: 1 loads midscale, 0 loads zero |
| load_n | input | 1 | Active-low load strobe; its level during reset sets the mode |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | Word address |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| rd_en | output | 1 | Bus drive enable for the pad ring |
| dac_code | output | 128 | Latched codes, channel n in bits [16n+15:16n] |
| offset_a | output | 16 | Group A offset code |
| offset_b | output | 16 | Group B offset code |
| mon_sel | output | 12 | Single-hot monitor select |
| mon_en | output | 1 | Monitor output enable |
| gpio_drive_low | output | 1 | 1 pulls the GPIO pin low, 0 leaves it floating |

## Verification
The update path is run in both modes, set by resetting once with the strobe high and once with it low.

In synchronous mode, writes to two channels followed by one strobe pulse show that latches hold across several idle cycles and then move together. In asynchronous mode the output code is sampled one and two edges after a write, with the strobe held high, which pins down the latency and shows the strobe is ignored.

Monitor writes carrying one, two and low-nibble bits separate accepted words from rejected ones. GPIO writes of all-zero and all-one data separate the stored bit from the discarded bits.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int MONW = 12;

  typedef enum logic [1:0] {
    KIND_MISC  = 2'd0,
    KIND_INPUT = 2'd1,
    KIND_ZERO  = 2'd2,
    KIND_GAIN  = 2'd3
  } reg_kind_e;

  localparam logic [2:0] MISC_CFG  = 3'd0;
  localparam logic [2:0] MISC_MON  = 3'd1;
  localparam logic [2:0] MISC_GPIO = 3'd2;
  localparam logic [2:0] MISC_OFFA = 3'd3;
  localparam logic [2:0] MISC_OFFB = 3'd4;

  localparam logic [DW-1:0] CODE_MID   = 16'h8000;
  localparam logic [DW-1:0] GAIN_UNITY = 16'hFFFF;
endpackage

// File: rtl/dacif_ctrl_regs.sv
module dacif_ctrl_regs
  import dacif_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            reset_sel,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   cfg_q,
  output logic [MONW-1:0] mon_q,
  output logic            gpio_q,
  output logic [DW-1:0]   off_a_q,
  output logic [DW-1:0]   off_b_q
);
  localparam logic [DW-1:0] ZERO_W = '0;
  logic mon_ok;
  assign mon_ok = ($countones(wdata[DW-1:DW-MONW]) <= 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= ZERO_W;
      mon_q   <= '0;
      gpio_q  <= 1'b1;
      off_a_q <= reset_sel ? CODE_MID : ZERO_W;
      off_b_q <= reset_sel ? CODE_MID : ZERO_W;
    end else if (wr_en) begin
      case (wr_sel)
        MISC_CFG:  cfg_q   <= wdata;
        MISC_MON:  if (mon_ok) mon_q <= wdata[DW-1:DW-MONW];
        MISC_GPIO: gpio_q  <= wdata[DW-1];
        MISC_OFFA: off_a_q <= wdata;
        MISC_OFFB: off_b_q <= wdata;
        default: ;
      endcase
    end
  end

  // R7
  mon_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(mon_q));
  // R8
  gpio_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == MISC_GPIO) |=> (gpio_q == $past(wdata[DW-1])));
  // R9
  offa_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == MISC_OFFA) |=> (off_a_q == $past(wdata)));
endmodule

// File: rtl/dacif_chan_bank.sv
module dacif_chan_bank
  import dacif_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reset_sel,
  input  logic              async_mode,
  input  logic              load_n,
  input  logic              wr_en,
  input  reg_kind_e         wr_kind,
  input  logic [CW-1:0]     wr_ch,
  input  logic [DW-1:0]     wdata,
  input  reg_kind_e         rd_kind,
  input  logic [CW-1:0]     rd_ch,
  output logic [DW-1:0]     rd_word,
  output logic [NCH*DW-1:0] dac_code
);
  logic [DW-1:0] in_q   [NCH];
  logic [DW-1:0] zero_q [NCH];
  logic [DW-1:0] gain_q [NCH];
  logic [DW-1:0] data_q [NCH];
  logic [DW-1:0] lat_q  [NCH];
  logic [DW-1:0] rst_code;
  logic          lat_open;

  assign rst_code = reset_sel ? CODE_MID : '0;
  assign lat_open = async_mode || !load_n;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (rst) begin
        in_q[i]   <= rst_code;
        zero_q[i] <= '0;
        gain_q[i] <= GAIN_UNITY;
        data_q[i] <= rst_code;
        lat_q[i]  <= rst_code;
      end else begin
        if (wr_en && wr_ch == CW'(i)) begin
          case (wr_kind)
            KIND_INPUT: in_q[i]   <= wdata;
            KIND_ZERO:  zero_q[i] <= wdata;
            KIND_GAIN:  gain_q[i] <= wdata;
            default: ;
          endcase
        end
        data_q[i] <= in_q[i];
        if (lat_open) lat_q[i] <= data_q[i];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (int'(rd_ch) < NCH) begin
      case (rd_kind)
        KIND_INPUT: rd_word = in_q[rd_ch];
        KIND_ZERO:  rd_word = zero_q[rd_ch];
        KIND_GAIN:  rd_word = gain_q[rd_ch];
        default:    rd_word = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign dac_code[g*DW +: DW] = lat_q[g];

    // R5
    sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!async_mode && load_n) |=> $stable(lat_q[g]));
    // R4
    data_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_kind == KIND_INPUT && wr_ch == CW'(g)) |=> ##1 (data_q[g] == $past(wdata, 2)));
    // R6
    async_path_chk: assert property (@(posedge clk) disable iff (rst)
      (async_mode && wr_en && wr_kind == KIND_INPUT && wr_ch == CW'(g))
        |-> ##3 (lat_q[g] == $past(wdata, 3)));
  end
endmodule

// File: rtl/dacif_regfile.sv
module dacif_regfile
  import dacif_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reset_sel,
  input  logic              load_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic [4:0]        addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rd_data,
  output logic              rd_en,
  output logic [NCH*16-1:0] dac_code,
  output logic [15:0]       offset_a,
  output logic [15:0]       offset_b,
  output logic [11:0]       mon_sel,
  output logic              mon_en,
  output logic              gpio_drive_low
);
  logic            async_q;
  logic            wr_go, rd_go;
  reg_kind_e       kind;
  logic [DW-1:0]   cfg_q, bank_word, rd_mux;
  logic [MONW-1:0] mon_q;
  logic            gpio_q;

  assign kind  = reg_kind_e'(addr[4:3]);
  assign wr_go = !cs_n && !rw;
  assign rd_go = !cs_n && rw;

  always_ff @(posedge clk) begin
    if (rst) async_q <= !load_n;
  end

  dacif_ctrl_regs u_ctrl (
    .clk(clk), .rst(rst), .reset_sel(reset_sel),
    .wr_en(wr_go && kind == KIND_MISC), .wr_sel(addr[2:0]), .wdata(wdata),
    .cfg_q(cfg_q), .mon_q(mon_q), .gpio_q(gpio_q),
    .off_a_q(offset_a), .off_b_q(offset_b)
  );

  dacif_chan_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst(rst), .reset_sel(reset_sel), .async_mode(async_q),
    .load_n(load_n), .wr_en(wr_go), .wr_kind(kind), .wr_ch(addr[2:0]),
    .wdata(wdata), .rd_kind(kind), .rd_ch(addr[2:0]),
    .rd_word(bank_word), .dac_code(dac_code)
  );

  always_comb begin
    rd_mux = bank_word;
    if (kind == KIND_MISC) begin
      case (addr[2:0])
        MISC_CFG:  rd_mux = cfg_q;
        MISC_MON:  rd_mux = {mon_q, 4'b0000};
        MISC_GPIO: rd_mux = {gpio_q, 15'b0};
        MISC_OFFA: rd_mux = offset_a;
        MISC_OFFB: rd_mux = offset_b;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_en   <= 1'b0;
    end else begin
      rd_data <= rd_go ? rd_mux : '0;
      rd_en   <= rd_go;
    end
  end

  assign mon_sel        = mon_q;
  assign mon_en         = |mon_q;
  assign gpio_drive_low = !gpio_q;

  // R3
  rd_en_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> $past(!cs_n && rw));
  // R3
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rd_data == 16'h0000));
endmodule

// File: tb/test_dacif_regfile.sv
module test_dacif_regfile;
  logic clk = 1'b0;
  logic rst, reset_sel, load_n, cs_n, rw;
  logic [4:0] addr;
  logic [15:0] wdata, rd_data, offset_a, offset_b;
  logic rd_en, mon_en, gpio_drive_low;
  logic [127:0] dac_code;
  logic [11:0] mon_sel;
  int total = 0;
  int bad = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  dacif_regfile i_dacif_regfile (
    .clk(clk), .rst(rst), .reset_sel(reset_sel), .load_n(load_n),
    .cs_n(cs_n), .rw(rw), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .rd_en(rd_en), .dac_code(dac_code),
    .offset_a(offset_a), .offset_b(offset_b), .mon_sel(mon_sel),
    .mon_en(mon_en), .gpio_drive_low(gpio_drive_low)
  );

  function automatic logic [15:0] code(int ch);
    return dac_code[ch*16 +: 16];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b1;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; addr = a;
    @(negedge clk);
    cs_n = 1'b1;
    chk("R3 rd_en during read", {31'b0, rd_en}, 32'd1);
    d = rd_data;
  endtask

  task automatic do_reset(logic sel, logic ld);
    @(negedge clk);
    rst = 1'b1; reset_sel = sel; load_n = ld;
    repeat (3) @(negedge clk);
    rst = 1'b0; load_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_sync;
    chk("R1 ch0 midscale", code(0), 16'h8000);
    chk("R1 ch7 midscale", code(7), 16'h8000);
    chk("R1 offset_a midscale", offset_a, 16'h8000);
    chk("R1 gpio released", gpio_drive_low, 0);
    chk("R1 monitor off", mon_en, 0);
    chk("R3 idle rd_en", rd_en, 0);
    rd(5'd16, rv); chk("R1 zero default", rv, 16'h0000);
    rd(5'd24, rv); chk("R1 gain default", rv, 16'hFFFF);
    rd(5'd2, rv);  chk("R1 gpio default", rv, 16'h8000);
    rd(5'd8, rv);  chk("R1 input default", rv, 16'h8000);
  endtask

  task automatic t_sync_update;
    wr(5'd11, 16'h1234);
    wr(5'd8, 16'h0F0F);
    repeat (3) @(negedge clk);
    chk("R5 hold while strobe high", code(3), 16'h8000);
    rd(5'd11, rv); chk("R2 input ch3 readback", rv, 16'h1234);
    load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    chk("R5 ch3 loaded", code(3), 16'h1234);
    chk("R5 ch0 loaded same edge", code(0), 16'h0F0F);
    wr(5'd11, 16'h5555);
    repeat (3) @(negedge clk);
    chk("R4 R5 new word held back", code(3), 16'h1234);
  endtask

  task automatic t_monitor;
    wr(5'd1, 16'h0010);
    chk("R7 sel bit", mon_sel, 12'h001);
    chk("R7 enable", mon_en, 1);
    wr(5'd1, 16'h0030);
    rd(5'd1, rv); chk("R7 two-hot ignored", rv, 16'h0010);
    wr(5'd1, 16'h800F);
    rd(5'd1, rv); chk("R7 low bits dropped", rv, 16'h8000);
    chk("R7 top sel", mon_sel, 12'h800);
    wr(5'd1, 16'h0000);
    chk("R7 disabled", mon_en, 0);
  endtask

  task automatic t_gpio;
    wr(5'd2, 16'h0000);
    chk("R8 drive low", gpio_drive_low, 1);
    rd(5'd2, rv); chk("R8 read low", rv, 16'h0000);
    wr(5'd2, 16'hFFFF);
    chk("R8 release", gpio_drive_low, 0);
    rd(5'd2, rv); chk("R8 only bit15", rv, 16'h8000);
  endtask

  task automatic t_direct;
    wr(5'd0, 16'hA5A5);
    chk("R3 no drive after write", rd_en, 0);
    rd(5'd0, rv); chk("R9 config readback", rv, 16'hA5A5);
    wr(5'd3, 16'h1111); chk("R9 offset_a", offset_a, 16'h1111);
    wr(5'd4, 16'h2222); chk("R9 offset_b", offset_b, 16'h2222);
    wr(5'd5, 16'hBEEF);
    rd(5'd5, rv); chk("R2 reserved zero", rv, 16'h0000);
    wr(5'd18, 16'h7FFF);
    rd(5'd18, rv); chk("R2 zero ch2", rv, 16'h7FFF);
    wr(5'd30, 16'h1357);
    rd(5'd30, rv); chk("R2 gain ch6", rv, 16'h1357);
    rd(5'd22, rv); chk("R2 gain ch6 not aliased", rv, 16'h0000);
  endtask

  task automatic t_async;
    do_reset(1'b0, 1'b0);
    chk("R1 ch7 zero code", code(7), 16'h0000);
    chk("R1 offset_b zero", offset_b, 16'h0000);
    wr(5'd15, 16'hABCD);
    @(negedge clk);
    chk("R6 not yet after k+1", code(7), 16'h0000);
    @(negedge clk);
    chk("R6 arrives after k+2", code(7), 16'hABCD);
    wr(5'd9, 16'h4321);
    repeat (2) @(negedge clk);
    chk("R6 strobe ignored", code(1), 16'h4321);
  endtask

  initial begin
    rst = 1'b1; reset_sel = 1'b1; load_n = 1'b1;
    cs_n = 1'b1; rw = 1'b1; addr = '0; wdata = '0;
    do_reset(1'b1, 1'b1);
    t_reset_sync();
    t_sync_update();
    t_monitor();
    t_gpio();
    t_direct();
    t_async();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule